// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It holds three predictors. A local predictor keeps one history per branch address and uses that history to select a saturating counter. A global predictor uses a single shared history register to select a counter. A chooser table, indexed by the same global history, decides which of the two answers to trust. A lookup gives the branch address and gets back a taken bit in the same cycle. The lookup also returns the global history value that was in force when the prediction was made.

Every lookup updates state speculatively on the next clock edge. The predicted outcome is shifted into the global history and into the addressed local history. The counters that produced the two component predictions step toward the predicted direction. When the branch resolves, the resolve port supplies the address, the global history captured at lookup time and the real outcome. The block then reloads the global history from that snapshot and retrains the local, global and chooser counters. It finishes by writing the real outcome into the history bits that were guessed.

Top module: `bpt_tournament_predictor`

## Requirements
- R1: After reset every counter and every history is zero. `lk_ghist` reads 0, and every address predicts not-taken.
- R2: The local history entry is chosen by `(lk_pc >> INST_SHIFT) mod LHT_ENTRIES`. Addresses that differ by `LHT_ENTRIES << INST_SHIFT` share an entry. At lookup, the local counter index equals the full selected local history.
- R3: A counter votes taken exactly when its value is greater than `((1 << (CTR_W-1)) - 1) / 2` with integer division. With the default `CTR_W` = 2, this means a value of 1, 2 or 3.
- R4: When the chooser counter at the current global history votes taken (greater than the threshold), `lk_taken` is the global prediction. Otherwise `lk_taken` is the local prediction.
- R5: A valid lookup changes state on the next edge as follows:
  - the global history becomes `{ghist, lk_taken}`, keeping its low `GHIST_W` bits;
  - the selected local history becomes `{lhist, lk_taken}`, keeping its low `LHIST_W` bits;
  - the local counter and the global counter that were read each step up when `lk_taken` is 1 and down when it is 0.
- R6: Every counter saturates at 0 and at `2^CTR_W - 1`.
- R7: A resolve sets the global history to `{rs_ghist, rs_taken}`, keeping its low `GHIST_W` bits.
- R8: At a resolve, the local counter is indexed by the stored local history shifted right by one. Bit 0 of that local history entry is then replaced by `rs_taken`, and its other bits are kept.
- R9: At a resolve, the chooser counter at `rs_ghist` is trained only when the local vote and the global vote differ. It steps down when the local vote equals `rs_taken` and steps up otherwise.
- R10: At a resolve, the local counter and the global counter indexed at resolve time both step toward `rs_taken`.
- R11: A lookup and a resolve may occur in the same cycle. The lookup result is taken from the state before the edge. The resolve's writes replace the lookup's writes to the global history, and to any local history entry or counter that both address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request; allows the speculative update |
| lk_pc | input | PC_W | Branch address for the lookup |
| lk_taken | output | 1 | Predicted direction (combinational from `lk_pc` and state) |
| lk_ghist | output | GHIST_W | Global history in force for this lookup |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_ghist | input | GHIST_W | Global history captured at that branch's lookup |
| rs_taken | input | 1 | Actual outcome of the branch |

## Verification
A lookup and a resolve can arrive in the same cycle. When they do, both want to write the global history, and they may also write the same local history entry or the same counter. The bench creates this case in a long mixed phase with random addresses in a small address range, so that collisions on one entry happen often. In the same phase, both valid inputs are raised together in many cycles. A bench model applies the lookup's writes first and then lets the resolve's writes override them. Every following prediction and history snapshot is compared with that model, which shows whether the surviving state is the one the resolve wrote.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    // Which component prediction the chooser picked
    typedef enum logic {
        SIDE_LOCAL  = 1'b0,
        SIDE_GLOBAL = 1'b1
    } bpt_side_e;

    // Training decision at resolve time
    typedef struct packed {
        logic local_vote;
        logic global_vote;
        logic disagree;
        logic local_right;
    } bpt_train_t;

    // Taken threshold derived from the counter width
    function automatic int unsigned bpt_thresh(input int unsigned w);
        return ((32'd1 << (w - 1)) - 32'd1) / 32'd2;
    endfunction

    // Saturating step of a counter up to 8 bits wide
    function automatic logic [7:0] bpt_sat_step(input logic [7:0] v,
                                                input logic up,
                                                input int unsigned w);
        logic [7:0] top;
        top = 8'((32'd1 << w) - 32'd1);
        if (up)
            return (v == top) ? v : v + 8'd1;
        else
            return (v == 8'd0) ? v : v - 8'd1;
    endfunction

endpackage

// File: rtl/bpt_ctr_table.sv
module bpt_ctr_table #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output logic [CTR_W-1:0] a_ctr,
    input  logic [IDX_W-1:0] b_idx,
    output logic [CTR_W-1:0] b_ctr,
    input  logic             spec_en,
    input  logic [IDX_W-1:0] spec_idx,
    input  logic             spec_up,
    input  logic             fix_en,
    input  logic [IDX_W-1:0] fix_idx,
    input  logic             fix_up
);
    logic [CTR_W-1:0] ctr [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                ctr[e] <= '0;
            else if (fix_en && (fix_idx == IDX_W'(e)))
                ctr[e] <= CTR_W'(bpt_pkg::bpt_sat_step(8'(ctr[e]), fix_up, CTR_W));
            else if (spec_en && (spec_idx == IDX_W'(e)))
                ctr[e] <= CTR_W'(bpt_pkg::bpt_sat_step(8'(ctr[e]), spec_up, CTR_W));
        end
    end

    assign a_ctr = ctr[a_idx];
    assign b_ctr = ctr[b_idx];
endmodule

// File: rtl/bpt_local_hist.sv
module bpt_local_hist #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int HIST_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [HIST_W-1:0] a_hist,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [HIST_W-1:0] b_hist,
    input  logic              spec_en,
    input  logic [IDX_W-1:0]  spec_idx,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [IDX_W-1:0]  fix_idx,
    input  logic              fix_bit
);
    logic [HIST_W-1:0] hist [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                hist[e] <= '0;
            else if (fix_en && (fix_idx == IDX_W'(e)))
                hist[e] <= (hist[e] & ~HIST_W'(1)) | HIST_W'(fix_bit);
            else if (spec_en && (spec_idx == IDX_W'(e)))
                hist[e] <= HIST_W'({hist[e], spec_bit});
        end
    end

    assign a_hist = hist[a_idx];
    assign b_hist = hist[b_idx];
endmodule

// File: rtl/bpt_global_hist.sv
module bpt_global_hist #(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (fix_en)
            hist <= HIST_W'({fix_hist, fix_bit});
        else if (spec_en)
            hist <= HIST_W'({hist, spec_bit});
    end
endmodule

// File: rtl/bpt_tournament_predictor.sv
module bpt_tournament_predictor #(
    parameter int PC_W        = 16,
    parameter int INST_SHIFT  = 2,
    parameter int LHT_ENTRIES = 8,
    parameter int LHIST_W     = 3,
    parameter int GHIST_W     = 3,
    parameter int CTR_W       = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [PC_W-1:0]    lk_pc,
    output logic               lk_taken,
    output logic [GHIST_W-1:0] lk_ghist,
    input  logic               rs_valid,
    input  logic [PC_W-1:0]    rs_pc,
    input  logic [GHIST_W-1:0] rs_ghist,
    input  logic               rs_taken
);
    import bpt_pkg::*;

    localparam int LHT_IDX_W = (LHT_ENTRIES > 1) ? $clog2(LHT_ENTRIES) : 1;
    localparam int LCT_DEPTH = 1 << LHIST_W;
    localparam int GCT_DEPTH = 1 << GHIST_W;
    localparam logic [CTR_W-1:0] THR = CTR_W'(bpt_thresh(CTR_W));

    // ---------------- index generation ----------------
    logic [LHT_IDX_W-1:0] lk_lht_idx, rs_lht_idx;
    logic [LHIST_W-1:0]   lk_lhist, rs_lhist, rs_lct_idx;
    logic [GHIST_W-1:0]   ghist;

    assign lk_lht_idx = LHT_IDX_W'(lk_pc >> INST_SHIFT);
    assign rs_lht_idx = LHT_IDX_W'(rs_pc >> INST_SHIFT);
    assign rs_lct_idx = rs_lhist >> 1;

    // ---------------- counter read values ----------------
    logic [CTR_W-1:0] lk_lctr, rs_lctr, lk_gctr, rs_gctr, lk_cctr, rs_cctr;

    // ---------------- lookup decision ----------------
    logic      lk_local_vote, lk_global_vote;
    bpt_side_e lk_side;

    assign lk_local_vote  = (lk_lctr > THR);
    assign lk_global_vote = (lk_gctr > THR);
    assign lk_side        = (lk_cctr > THR) ? SIDE_GLOBAL : SIDE_LOCAL;
    assign lk_taken       = (lk_side == SIDE_GLOBAL) ? lk_global_vote : lk_local_vote;
    assign lk_ghist       = ghist;

    // ---------------- resolve training decision ----------------
    bpt_train_t trn;

    always_comb begin
        trn.local_vote  = (rs_lctr > THR);
        trn.global_vote = (rs_gctr > THR);
        trn.disagree    = trn.local_vote ^ trn.global_vote;
        trn.local_right = (trn.local_vote == rs_taken);
    end

    // ---------------- state ----------------
    bpt_global_hist #(.HIST_W(GHIST_W)) u_ghr (
        .clk      (clk),
        .rst      (rst),
        .spec_en  (lk_valid),
        .spec_bit (lk_taken),
        .fix_en   (rs_valid),
        .fix_hist (rs_ghist),
        .fix_bit  (rs_taken),
        .hist     (ghist)
    );

    bpt_local_hist #(
        .ENTRIES (LHT_ENTRIES),
        .IDX_W   (LHT_IDX_W),
        .HIST_W  (LHIST_W)
    ) u_lht (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (lk_lht_idx),
        .a_hist   (lk_lhist),
        .b_idx    (rs_lht_idx),
        .b_hist   (rs_lhist),
        .spec_en  (lk_valid),
        .spec_idx (lk_lht_idx),
        .spec_bit (lk_taken),
        .fix_en   (rs_valid),
        .fix_idx  (rs_lht_idx),
        .fix_bit  (rs_taken)
    );

    bpt_ctr_table #(
        .DEPTH (LCT_DEPTH),
        .IDX_W (LHIST_W),
        .CTR_W (CTR_W)
    ) u_lct (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (lk_lhist),
        .a_ctr    (lk_lctr),
        .b_idx    (rs_lct_idx),
        .b_ctr    (rs_lctr),
        .spec_en  (lk_valid),
        .spec_idx (lk_lhist),
        .spec_up  (lk_taken),
        .fix_en   (rs_valid),
        .fix_idx  (rs_lct_idx),
        .fix_up   (rs_taken)
    );

    bpt_ctr_table #(
        .DEPTH (GCT_DEPTH),
        .IDX_W (GHIST_W),
        .CTR_W (CTR_W)
    ) u_gct (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (ghist),
        .a_ctr    (lk_gctr),
        .b_idx    (rs_ghist),
        .b_ctr    (rs_gctr),
        .spec_en  (lk_valid),
        .spec_idx (ghist),
        .spec_up  (lk_taken),
        .fix_en   (rs_valid),
        .fix_idx  (rs_ghist),
        .fix_up   (rs_taken)
    );

    // chooser: trained only on resolve disagreement; never speculative
    bpt_ctr_table #(
        .DEPTH (GCT_DEPTH),
        .IDX_W (GHIST_W),
        .CTR_W (CTR_W)
    ) u_cct (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (ghist),
        .a_ctr    (lk_cctr),
        .b_idx    (rs_ghist),
        .b_ctr    (rs_cctr),
        .spec_en  (1'b0),
        .spec_idx ('0),
        .spec_up  (1'b0),
        .fix_en   (rs_valid && trn.disagree),
        .fix_idx  (rs_ghist),
        .fix_up   (!trn.local_right)
    );

    // rs_cctr is available for checkers; keep it from being unused
    logic unused_ok;
    assign unused_ok = ^rs_cctr;
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
    parameter int GHIST_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_taken,
    input logic [GHIST_W-1:0] lk_ghist,
    input logic               rs_valid,
    input logic [GHIST_W-1:0] rs_ghist,
    input logic               rs_taken
);
    logic [GHIST_W-1:0] rs_next, lk_next;
    assign rs_next = GHIST_W'({rs_ghist, rs_taken});
    assign lk_next = GHIST_W'({lk_ghist, lk_taken});

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (lk_ghist == '0));

    p_spec_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !rs_valid) |=> (lk_ghist == $past(lk_next)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!lk_valid && !rs_valid) |=> $stable(lk_ghist));

    p_ghist_repair_r7: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !lk_valid) |=> (lk_ghist == $past(rs_next)));

    p_resolve_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && lk_valid) |=> (lk_ghist == $past(rs_next)));
endmodule

bind bpt_tournament_predictor bpt_checker #(.GHIST_W(GHIST_W)) u_bpt_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_taken (lk_taken),
    .lk_ghist (lk_ghist),
    .rs_valid (rs_valid),
    .rs_ghist (rs_ghist),
    .rs_taken (rs_taken)
);

// File: tb/tb_bpt_tournament_predictor.sv
module tb_bpt_tournament_predictor;
    localparam int PC_W = 16, SH = 2, LHT = 8, LW = 3, GW = 3, CW = 2;
    localparam int CMAX = (1 << CW) - 1;
    localparam int THR  = ((1 << (CW - 1)) - 1) / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0, rs_valid = 1'b0, rs_taken = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
    logic [GW-1:0] rs_ghist = '0;
    logic lk_taken;
    logic [GW-1:0] lk_ghist;

    always #5 clk = ~clk;

    bpt_tournament_predictor #(
        .PC_W(PC_W), .INST_SHIFT(SH), .LHT_ENTRIES(LHT),
        .LHIST_W(LW), .GHIST_W(GW), .CTR_W(CW)
    ) dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_ghist(lk_ghist),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_ghist(rs_ghist), .rs_taken(rs_taken)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference state
    int m_lh [LHT];
    int m_lc [1 << LW];
    int m_gc [1 << GW];
    int m_cc [1 << GW];
    int m_gh;

    function automatic int stepc(int v, bit up);
        if (up) return (v < CMAX) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic bit model_pred(int pc);
        int li, gi;
        bit lv, gv;
        li = m_lh[(pc >> SH) % LHT];
        gi = m_gh;
        lv = (m_lc[li] > THR);
        gv = (m_gc[gi] > THR);
        return (m_cc[gi] > THR) ? gv : lv;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < LHT; i++) m_lh[i] = 0;
        for (int i = 0; i < (1 << LW); i++) m_lc[i] = 0;
        for (int i = 0; i < (1 << GW); i++) begin m_gc[i] = 0; m_cc[i] = 0; end
        m_gh = 0;
    endtask

    // lookup writes first, resolve writes override (R11)
    task automatic model_step(bit lv, int lpc, bit rv, int rpc, int rgh, bit ract);
        int n_lh [LHT];
        int n_lc [1 << LW];
        int n_gc [1 << GW];
        int n_cc [1 << GW];
        int n_gh;
        n_lh = m_lh; n_lc = m_lc; n_gc = m_gc; n_cc = m_cc; n_gh = m_gh;
        if (lv) begin
            int hi, li, gi;
            bit p;
            p  = model_pred(lpc);
            hi = (lpc >> SH) % LHT;
            li = m_lh[hi];
            gi = m_gh;
            n_lh[hi] = ((m_lh[hi] << 1) | p) & ((1 << LW) - 1);
            n_lc[li] = stepc(m_lc[li], p);
            n_gc[gi] = stepc(m_gc[gi], p);
            n_gh     = ((m_gh << 1) | p) & ((1 << GW) - 1);
        end
        if (rv) begin
            int hi, li;
            bit lvote, gvote;
            hi = (rpc >> SH) % LHT;
            li = m_lh[hi] >> 1;
            lvote = (m_lc[li] > THR);
            gvote = (m_gc[rgh] > THR);
            n_lc[li]  = stepc(m_lc[li], ract);
            n_gc[rgh] = stepc(m_gc[rgh], ract);
            if (lvote != gvote) n_cc[rgh] = stepc(m_cc[rgh], lvote != ract);
            n_gh     = ((rgh << 1) | ract) & ((1 << GW) - 1);
            n_lh[hi] = (m_lh[hi] & ~1) | ract;
        end
        m_lh = n_lh; m_lc = n_lc; m_gc = n_gc; m_cc = n_cc; m_gh = n_gh;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare mid-cycle, model follows the edge
    task automatic cycle(string tag, bit lv, int lpc, bit rv, int rpc, int rgh, bit ract);
        @(negedge clk);
        lk_valid = lv; lk_pc = PC_W'(lpc);
        rs_valid = rv; rs_pc = PC_W'(rpc); rs_ghist = GW'(rgh); rs_taken = ract;
        #1;
        check(tag, "lk_taken", int'(lk_taken), int'(model_pred(lpc)));
        check(tag, "lk_ghist", int'(lk_ghist), m_gh);
        @(posedge clk);
        model_step(lv, lpc, rv, rpc, rgh, ract);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: everything clear, every address not-taken
        for (int pc = 0; pc < 64; pc += 4) cycle("R1", 0, pc, 0, 0, 0, 0);

        // R5 R6: lookups only from the reset state, counters held at zero
        for (int i = 0; i < 64; i++) cycle("R5_R6", 1, i * 4, 0, 0, 0, 0);

        // R7 R8 R10: resolves only, mostly taken, with observing lookups
        for (int i = 0; i < 300; i++) begin
            cycle("R7_R8_R10", 0, 0, 1, int'($urandom_range(0, 63)),
                  int'($urandom_range(0, (1 << GW) - 1)), ($urandom_range(0, 3) != 0));
            cycle("R2_R3", 0, int'($urandom_range(0, 255)), 0, 0, 0, 0);
        end

        // R6: hammer one entry to the top and back to the bottom
        for (int i = 0; i < 8; i++) cycle("R6", 0, 0, 1, 12, 5, 1);
        cycle("R6", 0, 12, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cycle("R6", 0, 0, 1, 12, 5, 0);
        cycle("R6", 0, 12, 0, 0, 0, 0);

        // R2: aliasing addresses 32 bytes apart read the same entry
        for (int i = 0; i < 64; i++) cycle("R2", 1, (i % 8) * 4 + 32 * (i / 8), 0, 0, 0, 0);

        // R9 R4: resolve outcomes alternating to split local and global votes
        for (int i = 0; i < 600; i++)
            cycle("R9_R4", (i % 3 == 0), int'($urandom_range(0, 31)), 1,
                  int'($urandom_range(0, 31)), int'($urandom_range(0, (1 << GW) - 1)), i[1]);

        // R11: dense mixed traffic with many same-cycle collisions
        for (int i = 0; i < 3000; i++) begin
            int a;
            a = int'($urandom_range(0, 15));
            cycle("R11", ($urandom_range(0, 3) != 0), a,
                  ($urandom_range(0, 2) != 0), ($urandom_range(0, 1) != 0) ? a : int'($urandom_range(0, 15)),
                  int'($urandom_range(0, (1 << GW) - 1)), $urandom_range(0, 1) != 0);
        end

        // R5 R3 R4: lookups only after training, speculative drift
        for (int i = 0; i < 200; i++) cycle("R3_R4_R5", 1, int'($urandom_range(0, 127)), 0, 0, 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule